// File: doc/BRIEF.md
# Exception Priority Resolver with Delay-Slot Legality Check

This block sits beside the retire stage of a small RISC pipeline. When several exception conditions are present together, it picks the one that is taken. Its inputs are the request flags from every exception source and the decoded class of the instruction that is retiring. It reports the winner as a 4-bit code and as a one-hot vector, together with a one-cycle valid pulse. When the winner is a peripheral interrupt, it also gives the index of that peripheral.

The block keeps its own record of whether the retiring instruction sits in the slot after a delayed branch. It uses that record to raise an illegal-slot exception when an undefined opcode, a PC-changing instruction or a trap occupies that slot. The two reset requests are level inputs and act in any cycle. Every other request counts only in a cycle where the instruction-boundary strobe is high.

Top module: `exc_prio_resolver`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, `exc_valid`, `illegal_slot` and `in_slot` are 0, and `exc_code`, `exc_onehot` and `periph_idx` are all zero.
- R2: `por_req` and `dbg_rst_req` act whatever the state of `boundary` and of the other requests. `por_req` gives code 1 and, without it, `dbg_rst_req` gives code 2, in the cycle after the edge.
- R3: When several requests are present on an edge, the output shows the highest one. From highest to lowest the codes are: 1 power-on reset, 2 debug reset, 3 break before execution, 4 fetch address error, 5 general illegal, 6 illegal slot, 7 trap, 8 data address error, 9 break after execution, 10 NMI, 11 debug interrupt, 12 external IRQ, 13 peripheral.
- R4: `exc_valid` is high for exactly the cycle after an edge on which at least one request counts. Otherwise `exc_valid` is 0 and `exc_code` is 0.
- R5: On an edge where `boundary` is 0, every request other than the two resets has no effect on the outputs.
- R6: An undefined opcode (`ins_undef`) that retires outside a delay slot gives code 5, and `illegal_slot` stays low.
- R7: While `in_slot` is 1, a retiring instruction whose class has any of `ins_undef`, `ins_dly_branch`, `ins_pc_change` or `ins_trap` set gives code 6 with `illegal_slot` high. It never gives code 5 or 7.
- R8: `in_slot` becomes 1 after a boundary edge whose instruction is a delayed branch and on which no exception is taken. It returns to 0 on the next boundary edge that does not itself retire a delayed branch. It also clears on any edge where an exception is taken.
- R9: Among peripheral requests, bit 0 of `periph_req` has the highest priority and higher bits have lower priority. `periph_idx` gives the index of the winning bit when the code is 13, and is 0 otherwise.
- R10: `exc_onehot` has bit (code−1) set when `exc_valid` is high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_req | input | 1 | Power-on reset request (level) |
| dbg_rst_req | input | 1 | Debug-interface reset request (level) |
| boundary | input | 1 | An instruction retires this cycle; other requests are sampled |
| brk_pre | input | 1 | Break before execution |
| ifetch_aerr | input | 1 | Address error on instruction fetch |
| ins_undef | input | 1 | Retiring opcode is undefined |
| ins_dly_branch | input | 1 | Retiring instruction is a delayed branch |
| ins_pc_change | input | 1 | Retiring instruction changes the PC without a delay slot (conditional branch, status-register load) |
| ins_trap | input | 1 | Retiring instruction is a trap |
| daccess_aerr | input | 1 | Address error on data access |
| brk_post | input | 1 | Break after execution or operand break |
| nmi | input | 1 | Non-maskable interrupt |
| dbg_irq | input | 1 | Debug-interface interrupt |
| irq_ext | input | 1 | External interrupt request |
| periph_req | input | NUM_PERIPH (7) | On-chip peripheral requests, bit 0 highest |
| exc_valid | output | 1 | Winner valid pulse |
| exc_code | output | 4 | Winning code 1..13, 0 when none |
| exc_onehot | output | 13 | One-hot form of the winning code |
| illegal_slot | output | 1 | Winner is an illegal-slot exception |
| periph_idx | output | PIDX_W (3) | Index of the winning peripheral |
| in_slot | output | 1 | Next retiring instruction occupies a delay slot |

## Verification
The bench builds the block with NUM_PERIPH at its default of 7. This makes all seven peripheral lines reachable, so the fixed peripheral order and the 3-bit index can be checked, including the highest index. With one fixed width, the test effort goes into ordering. The bench walks a request ladder that removes one level at a time. It also places every forbidden class in a delay slot, holds the slot over non-boundary cycles, and clears it through a taken interrupt, through a reset request and through `rst_n`.

// File: rtl/exc_pkg.sv
// Package: shared codes and widths for the exception priority resolver.
// Assumes codes are ordered so that a smaller nonzero code wins.
package exc_pkg;

    localparam int NUM_LVL = 13;
    localparam int CODE_W  = 4;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE     = 4'd0,
        EXC_POR      = 4'd1,
        EXC_DBG_RST  = 4'd2,
        EXC_BRK_PRE  = 4'd3,
        EXC_IF_AERR  = 4'd4,
        EXC_GEN_ILL  = 4'd5,
        EXC_SLOT_ILL = 4'd6,
        EXC_TRAP     = 4'd7,
        EXC_DA_AERR  = 4'd8,
        EXC_BRK_POST = 4'd9,
        EXC_NMI      = 4'd10,
        EXC_DBG_IRQ  = 4'd11,
        EXC_IRQ      = 4'd12,
        EXC_PERIPH   = 4'd13
    } exc_code_e;

endpackage

// File: rtl/exc_fixed_prio.sv
// Module: exc_fixed_prio
// Fixed-priority picker: bit 0 of req has the highest priority. It gives a
// one-hot grant, the binary index of the granted bit and an any-request flag.
// Assumes N >= 1. Purely combinational.
module exc_fixed_prio #(
    parameter  int N     = 13,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // seen[i] is high when a higher-priority bit (index below i) is requesting
    logic [N-1:0] seen;

    assign seen[0] = 1'b0;
    generate
        for (genvar i = 1; i < N; i++) begin : g_seen
            assign seen[i] = |req[i-1:0];
        end
    endgenerate

    // Grant the first requesting bit only
    assign grant = req & ~seen;
    assign any   = |req;

    // Binary-encode the one-hot grant by OR-ing the indices of granted bits
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/exc_slot_tracker.sv
// Module: exc_slot_tracker
// Keeps the delay-slot flag and sorts the retiring instruction's class into
// the general-illegal, illegal-slot and trap requests.
// Assumes class flags are meaningful only while boundary is high, and that
// take_exc reports any exception taken on the same edge.
module exc_slot_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic ins_undef,
    input  logic ins_dly_branch,
    input  logic ins_pc_change,
    input  logic ins_trap,
    input  logic take_exc,
    output logic in_slot,
    output logic gen_ill_req,
    output logic slot_ill_req,
    output logic trap_req
);

    logic forbidden_in_slot;

    // Classes that may not occupy a delay slot
    assign forbidden_in_slot = ins_undef | ins_dly_branch | ins_pc_change | ins_trap;

    // Classify the retiring instruction against the current slot state
    always_comb begin
        gen_ill_req  = boundary & ins_undef & ~in_slot;
        trap_req     = boundary & ins_trap  & ~in_slot;
        slot_ill_req = boundary & in_slot   & forbidden_in_slot;
    end

    // Slot flag: set by a retiring delayed branch, cleared by the next retire or a taken exception
    always_ff @(posedge clk) begin
        if (!rst_n)        in_slot <= 1'b0;
        else if (take_exc) in_slot <= 1'b0;
        else if (boundary) in_slot <= ins_dly_branch;
    end

endmodule

// File: rtl/exc_prio_resolver.sv
// Module: exc_prio_resolver (top)
// Builds the thirteen-level request vector from reset levels, boundary-gated
// sources, slot-tracker results and the peripheral arbiter. It picks the
// winner and registers the code, one-hot vector, valid pulse, slot flag and
// peripheral index.
// Assumes requests are stable around the rising clock edge.
module exc_prio_resolver
    import exc_pkg::*;
#(
    parameter  int NUM_PERIPH = 7,
    localparam int PIDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  por_req,
    input  logic                  dbg_rst_req,
    input  logic                  boundary,
    input  logic                  brk_pre,
    input  logic                  ifetch_aerr,
    input  logic                  ins_undef,
    input  logic                  ins_dly_branch,
    input  logic                  ins_pc_change,
    input  logic                  ins_trap,
    input  logic                  daccess_aerr,
    input  logic                  brk_post,
    input  logic                  nmi,
    input  logic                  dbg_irq,
    input  logic                  irq_ext,
    input  logic [NUM_PERIPH-1:0] periph_req,
    output logic                  exc_valid,
    output logic [CODE_W-1:0]     exc_code,
    output logic [NUM_LVL-1:0]    exc_onehot,
    output logic                  illegal_slot,
    output logic [PIDX_W-1:0]     periph_idx,
    output logic                  in_slot
);

    localparam int LVL_IDX_W = $clog2(NUM_LVL);

    logic                  gen_ill_req, slot_ill_req, trap_req;
    logic                  take_exc;
    logic [NUM_LVL-1:0]    lvl_req, lvl_grant;
    logic [LVL_IDX_W-1:0]  lvl_idx;
    logic [NUM_PERIPH-1:0] per_grant;
    logic [PIDX_W-1:0]     per_idx;
    logic                  per_any;
    logic [CODE_W-1:0]     next_code;

    // Delay-slot state and instruction-class requests
    exc_slot_tracker u_slot (
        .clk            (clk),
        .rst_n          (rst_n),
        .boundary       (boundary),
        .ins_undef      (ins_undef),
        .ins_dly_branch (ins_dly_branch),
        .ins_pc_change  (ins_pc_change),
        .ins_trap       (ins_trap),
        .take_exc       (take_exc),
        .in_slot        (in_slot),
        .gen_ill_req    (gen_ill_req),
        .slot_ill_req   (slot_ill_req),
        .trap_req       (trap_req)
    );

    // Fixed order among on-chip peripheral lines
    exc_fixed_prio #(.N(NUM_PERIPH)) u_per (
        .req   (periph_req),
        .grant (per_grant),
        .idx   (per_idx),
        .any   (per_any)
    );

    // Assemble the level vector; index 0 is the highest priority
    always_comb begin
        lvl_req     = '0;
        lvl_req[0]  = por_req;
        lvl_req[1]  = dbg_rst_req;
        lvl_req[2]  = boundary & brk_pre;
        lvl_req[3]  = boundary & ifetch_aerr;
        lvl_req[4]  = gen_ill_req;
        lvl_req[5]  = slot_ill_req;
        lvl_req[6]  = trap_req;
        lvl_req[7]  = boundary & daccess_aerr;
        lvl_req[8]  = boundary & brk_post;
        lvl_req[9]  = boundary & nmi;
        lvl_req[10] = boundary & dbg_irq;
        lvl_req[11] = boundary & irq_ext;
        lvl_req[12] = boundary & per_any;
    end

    // Pick the winning level
    exc_fixed_prio #(.N(NUM_LVL)) u_lvl (
        .req   (lvl_req),
        .grant (lvl_grant),
        .idx   (lvl_idx),
        .any   (take_exc)
    );

    // Turn the winning index into a 1-based code
    assign next_code = take_exc ? (CODE_W'(lvl_idx) + CODE_W'(1)) : CODE_W'(EXC_NONE);

    // Register the result; valid lasts one cycle per qualifying edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid    <= 1'b0;
            exc_code     <= '0;
            exc_onehot   <= '0;
            illegal_slot <= 1'b0;
            periph_idx   <= '0;
        end else begin
            exc_valid    <= take_exc;
            exc_code     <= next_code;
            exc_onehot   <= lvl_grant;
            illegal_slot <= lvl_grant[5];
            periph_idx   <= lvl_grant[12] ? per_idx : '0;
        end
    end

    // R1: a reset edge leaves every output quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!exc_valid && exc_code == '0 && !in_slot && !illegal_slot));

    // R2: power-on reset wins regardless of the boundary strobe
    a_r2_por_wins: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> (exc_valid && exc_code == CODE_W'(EXC_POR)));

    // R5: without a boundary or a reset request nothing is reported
    a_r5_no_boundary_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !por_req && !dbg_rst_req) |=> !exc_valid);

    // R6: undefined opcode outside a slot is a general illegal
    a_r6_general_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ins_undef && !in_slot && !por_req && !dbg_rst_req && !brk_pre && !ifetch_aerr)
        |=> (exc_code == CODE_W'(EXC_GEN_ILL) && !illegal_slot));

    // R7: undefined opcode in a slot raises the slot exception
    a_r7_slot_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ins_undef && in_slot && !por_req && !dbg_rst_req && !brk_pre && !ifetch_aerr)
        |=> (illegal_slot && exc_code == CODE_W'(EXC_SLOT_ILL)));

    // R8: the slot flag only rises after a retiring delayed branch
    a_r8_slot_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_slot) |-> $past(boundary && ins_dly_branch));

    // R10: the one-hot output is empty or matches the code
    a_r10_onehot_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_onehot) && (!exc_valid || exc_onehot[exc_code - CODE_W'(1)]));

endmodule

// File: tb/sim_exc_prio_resolver.sv
// Scoreboard bench: the driver pushes expected results; the monitor pops
// them a quarter period after each rising edge and compares.
module sim_exc_prio_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 7;

    typedef struct {
        logic        v;
        logic [3:0]  code;
        logic [12:0] oh;
        logic        sl;
        logic [2:0]  pidx;
        logic        ins;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, por_req, dbg_rst_req, boundary, brk_pre, ifetch_aerr;
    logic ins_undef, ins_dly_branch, ins_pc_change, ins_trap;
    logic daccess_aerr, brk_post, nmi, dbg_irq, irq_ext;
    logic [NP-1:0] periph_req;
    logic          exc_valid, illegal_slot, in_slot;
    logic [3:0]    exc_code;
    logic [12:0]   exc_onehot;
    logic [2:0]    periph_idx;

    exp_t q[$];
    logic m_slot = 1'b0;
    int   n_chk  = 0;
    int   n_err  = 0;
    bit   done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_prio_resolver #(.NUM_PERIPH(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .dbg_rst_req(dbg_rst_req),
        .boundary(boundary), .brk_pre(brk_pre), .ifetch_aerr(ifetch_aerr),
        .ins_undef(ins_undef), .ins_dly_branch(ins_dly_branch),
        .ins_pc_change(ins_pc_change), .ins_trap(ins_trap),
        .daccess_aerr(daccess_aerr), .brk_post(brk_post), .nmi(nmi),
        .dbg_irq(dbg_irq), .irq_ext(irq_ext), .periph_req(periph_req),
        .exc_valid(exc_valid), .exc_code(exc_code), .exc_onehot(exc_onehot),
        .illegal_slot(illegal_slot), .periph_idx(periph_idx), .in_slot(in_slot)
    );

    task automatic clr();
        por_req = 0; dbg_rst_req = 0; boundary = 0; brk_pre = 0; ifetch_aerr = 0;
        ins_undef = 0; ins_dly_branch = 0; ins_pc_change = 0; ins_trap = 0;
        daccess_aerr = 0; brk_post = 0; nmi = 0; dbg_irq = 0; irq_ext = 0;
        periph_req = '0;
    endtask

    // Reference model built from the requirement text
    task automatic model(input string tag);
        exp_t        e;
        logic [12:0] r;
        logic        forb;
        int          k;
        e.tag = tag; e.v = 0; e.code = 0; e.oh = 0; e.sl = 0; e.pidx = 0; e.ins = 0;
        if (rst_n) begin
            forb = ins_undef | ins_dly_branch | ins_pc_change | ins_trap;
            r = '0;
            r[0] = por_req; r[1] = dbg_rst_req;
            if (boundary) begin
                r[2] = brk_pre; r[3] = ifetch_aerr;
                r[4] = ins_undef & !m_slot; r[5] = m_slot & forb; r[6] = ins_trap & !m_slot;
                r[7] = daccess_aerr; r[8] = brk_post; r[9] = nmi; r[10] = dbg_irq;
                r[11] = irq_ext; r[12] = |periph_req;
            end
            k = -1;
            for (int i = 12; i >= 0; i--) if (r[i]) k = i;
            if (k >= 0) begin
                e.v = 1; e.code = 4'(k + 1); e.oh = 13'(1) << k; e.sl = (k == 5);
                if (k == 12) begin
                    for (int j = NP - 1; j >= 0; j--) if (periph_req[j]) e.pidx = 3'(j);
                end
                e.ins = 0;
            end else begin
                e.ins = boundary ? ins_dly_branch : m_slot;
            end
        end
        m_slot = e.ins;
        q.push_back(e);
    endtask

    // Driver step: record expectation, then let one edge pass
    task automatic step(input string tag);
        model(tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each result a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "valid", int'(exc_valid), int'(e.v));
            chk(e.tag, "code", int'(exc_code), int'(e.code));
            chk(e.tag, "illegal_slot", int'(illegal_slot), int'(e.sl));
            chk(e.tag, "in_slot", int'(in_slot), int'(e.ins));
            chk(e.tag, "periph_idx", int'(periph_idx), int'(e.pidx));
            chk({e.tag, "/R10"}, "onehot", int'(exc_onehot), int'(e.oh));
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        clr(); rst_n = 0;
        nmi = 1; boundary = 1; ins_dly_branch = 1;
        step("R1"); step("R1");
        clr(); rst_n = 1;
        step("R4");                                  // R4 idle: no valid
        nmi = 1; brk_pre = 1; periph_req = 7'h7F;    // R5 no boundary
        step("R5");
        ins_dly_branch = 1; step("R5");              // R5 slot not set without boundary
        clr();
        por_req = 1; nmi = 1; step("R2");            // R2 POR without boundary
        por_req = 1; step("R2");                     // R2 level held
        clr(); dbg_rst_req = 1; boundary = 1; nmi = 1; step("R2");
        por_req = 1; step("R2");
        clr();
        // R3 ladder: drop the top level one at a time
        boundary = 1; brk_pre = 1; ifetch_aerr = 1; ins_undef = 1; ins_trap = 1;
        daccess_aerr = 1; brk_post = 1; nmi = 1; dbg_irq = 1; irq_ext = 1; periph_req = 7'h08;
        step("R3"); brk_pre = 0;
        step("R3"); ifetch_aerr = 0;
        step("R3"); ins_undef = 0;
        step("R3"); ins_trap = 0;
        step("R3"); daccess_aerr = 0;
        step("R3"); brk_post = 0;
        step("R3"); nmi = 0;
        step("R3"); dbg_irq = 0;
        step("R3"); irq_ext = 0;
        step("R3"); periph_req = '0;
        step("R4");
        clr();
        boundary = 1; ins_undef = 1; step("R6");
        clr(); boundary = 1; ins_trap = 1; daccess_aerr = 1; step("R3");
        // R7: each forbidden class in a delay slot
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        clr(); step("R8");                           // held across a non-boundary cycle
        boundary = 1; ins_undef = 1; step("R7");
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        clr(); boundary = 1; ins_pc_change = 1; step("R7");
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        clr(); boundary = 1; ins_trap = 1; daccess_aerr = 1; step("R7");
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        step("R7");                                  // branch in slot: slot exc, flag cleared
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        clr(); boundary = 1; ins_undef = 1; brk_pre = 1; step("R3");
        // R8 clearing paths
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        clr(); boundary = 1; step("R8");             // plain retire clears
        clr(); boundary = 1; ins_dly_branch = 1; nmi = 1; step("R8");
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        clr(); por_req = 1; step("R8");
        clr(); boundary = 1; ins_dly_branch = 1; step("R8");
        clr(); rst_n = 0; step("R1");
        rst_n = 1; boundary = 1; ins_undef = 1; step("R6");
        // R9 peripheral order and index
        for (int i = 0; i < NP; i++) begin
            clr(); boundary = 1; periph_req = NP'(1) << i; step("R9");
        end
        clr(); boundary = 1; periph_req = 7'b1000100; step("R9");
        periph_req = 7'b1100000; step("R9");
        periph_req = 7'h7F; step("R9");
        periph_req = 7'h7F; irq_ext = 1; step("R9");
        clr(); step("R4");
        wait (q.size() == 0);
        #(CLK_PERIOD);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule